// File: doc/BRIEF.md
# Burst Memory Slave with Byte Masks

This block is an on-chip memory target for a memory bus that carries requests and replies on two separate valid/ready streams. A request carries a one-bit opcode, a byte start address, a burst length in bytes, write data with a per-byte enable, and two opaque tag fields (a source identifier and a context word). The block stores the data in a synchronous-read RAM, streams read data back one word per beat, and sends a single reply at the end of each write burst. Both tag fields come back unchanged on every reply beat.

The memory holds `DEPTH` words of `DATA_W` bits. A burst whose word range would run past the last word is refused with an error reply and leaves the memory untouched. The request stream stalls while replies are outstanding, so one burst is handled at a time. The RAM is read only through a clocked output register, which suits FPGA block memories.

Top module: `burstram_slave`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: With `B = DATA_W/8`, a burst covers `ceil(len/B)` words, and a length of 0 counts as one word. Its first word is `addr / B`, with the low address bits dropped, and each later beat uses the next word. Read data on beat k equals the word at `addr/B + k`.
- R3: On a write beat, byte lane i (bits `8i+7:8i`) is stored only when `cmd_mask[i]` is 1. Unmasked lanes keep their old contents.
- R4: `cmd_op` = 1 selects write. A write burst takes one request beat per word, with no reply during the beats. After the last beat it gives exactly one reply with `rsp_last` = 1.
- R5: `cmd_op` = 0 selects read. Reply beats start the cycle after the request is accepted. There is one beat per word, and `rsp_last` is 1 on the final beat only.
- R6: Every reply beat carries the request's `cmd_src` and `cmd_ctx`. These stay unchanged across all beats of a read burst.
- R7: `rsp_status` is 0 for success and 1 for error. A burst is an error when its first word plus its word count exceeds `DEPTH`. An erroneous read gives one beat with status 1 and `rsp_last` = 1. An erroneous write consumes all its beats, gives one status-1 reply, and changes no memory word.
- R8: `cmd_ready` is 0 whenever `rsp_valid` is 1, so no request is taken while replies are pending.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, every reply output holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request beat present |
| cmd_ready | output | 1 | Request beat accepted this cycle |
| cmd_op | input | 1 | 0 read, 1 write |
| cmd_addr | input | ADDR_W | Byte start address of the burst |
| cmd_len | input | LEN_W | Burst length in bytes |
| cmd_src | input | SRC_W | Source tag, echoed |
| cmd_ctx | input | CTX_W | Context tag, echoed |
| cmd_data | input | DATA_W | Write data of this beat |
| cmd_mask | input | DATA_W/8 | Byte enables of this beat |
| rsp_valid | output | 1 | Reply beat present |
| rsp_ready | input | 1 | Reply beat taken this cycle |
| rsp_status | output | 1 | 0 success, 1 error |
| rsp_last | output | 1 | Final beat of the reply |
| rsp_src | output | SRC_W | Echoed source tag |
| rsp_ctx | output | CTX_W | Echoed context tag |
| rsp_data | output | DATA_W | Read data, zero on write and error replies |

## Verification
On every cycle, the assertions check the stream rules: reply outputs hold under a stall, requests are blocked while a reply is pending, error replies are single final beats, tags stay steady between read beats, a read's first beat follows its acceptance at once, and nothing follows a final beat. The data path can be seen only in the bench's scenarios. These cover word addressing from unaligned byte addresses, length rounding including zero, byte-lane masking, and the fact that a refused write leaves every memory word intact. The bench sweeps all start words against a spread of lengths and all sixteen mask patterns, and it checks the results against an arithmetic model.

// File: rtl/burstram_pkg.sv
package burstram_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } cmd_op_e;

    typedef enum logic {
        STAT_OK  = 1'b0,
        STAT_ERR = 1'b1
    } rsp_stat_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WBEATS,
        SQ_RSTREAM,
        SQ_RSINGLE
    } seq_state_e;

    // Words touched by a burst of len_bytes; zero length still moves one word.
    function automatic int unsigned beat_count(input int unsigned len_bytes,
                                               input int unsigned bytes_per_word);
        if (len_bytes == 0)
            return 1;
        return (len_bytes + bytes_per_word - 1) / bytes_per_word;
    endfunction

endpackage

// File: rtl/burstram_decode.sv
module burstram_decode
    import burstram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 7,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic [ADDR_W-1:0]                 byte_addr,
    input  logic [LEN_W-1:0]                  len,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] word_addr,
    output logic [LEN_W:0]                    beats,
    output logic                              out_of_range
);
    localparam int BPW   = DATA_W / 8;
    localparam int OFF   = $clog2(BPW);
    localparam int WA_W  = ADDR_W - OFF;
    localparam int SUM_W = ((WA_W > LEN_W) ? WA_W : LEN_W) + 2;

    logic [SUM_W-1:0] span_end;

    assign word_addr    = WA_W'(byte_addr >> OFF);
    assign beats        = (LEN_W+1)'(beat_count(32'(len), BPW));
    assign span_end     = SUM_W'(word_addr) + SUM_W'(beats);
    assign out_of_range = span_end > SUM_W'(DEPTH);
endmodule

// File: rtl/burstram_store.sv
module burstram_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic                      re,
    input  logic [$clog2(DEPTH)-1:0]  addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [DATA_W/8-1:0]       wmask,
    output logic [DATA_W-1:0]         rdata
);
    localparam int BPW = DATA_W / 8;

    for (genvar g = 0; g < BPW; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        logic [7:0] lane_q;

        always_ff @(posedge clk) begin
            if (we && wmask[g])
                lane_mem[addr] <= wdata[g*8 +: 8];
            if (re)
                lane_q <= lane_mem[addr];
        end

        assign rdata[g*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/burstram_seq.sv
module burstram_seq
    import burstram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 7,
    parameter int DATA_W = 32,
    parameter int SRC_W  = 4,
    parameter int CTX_W  = 5,
    parameter int DEPTH  = 64
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cmd_valid,
    output logic                                cmd_ready,
    input  logic                                cmd_op,
    input  logic [SRC_W-1:0]                    cmd_src,
    input  logic [CTX_W-1:0]                    cmd_ctx,
    input  logic [DATA_W-1:0]                   cmd_data,
    input  logic [DATA_W/8-1:0]                 cmd_mask,
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]  dec_word,
    input  logic [LEN_W:0]                      dec_beats,
    input  logic                                dec_oor,
    output logic                                rsp_valid,
    input  logic                                rsp_ready,
    output logic                                rsp_status,
    output logic                                rsp_last,
    output logic [SRC_W-1:0]                    rsp_src,
    output logic [CTX_W-1:0]                    rsp_ctx,
    output logic [DATA_W-1:0]                   rsp_data,
    output logic                                ram_we,
    output logic                                ram_re,
    output logic [$clog2(DEPTH)-1:0]            ram_addr,
    output logic [DATA_W-1:0]                   ram_wdata,
    output logic [DATA_W/8-1:0]                 ram_wmask,
    input  logic [DATA_W-1:0]                   ram_q
);
    localparam int OFF  = $clog2(DATA_W / 8);
    localparam int WA_W = ADDR_W - OFF;
    localparam int IX_W = $clog2(DEPTH);
    localparam logic [LEN_W:0] ONE_BEAT = (LEN_W+1)'(1);

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [CTX_W-1:0] ctx;
        logic             err;
        logic [WA_W-1:0]  cur;
        logic [LEN_W:0]   left;
    } burst_t;

    seq_state_e state_q;
    burst_t     bq;
    logic       cmd_fire;
    logic       rsp_fire;
    logic       is_write;
    logic       final_beat;

    assign is_write   = cmd_op_e'(cmd_op) == OP_WRITE;
    assign cmd_ready  = (state_q == SQ_IDLE) || (state_q == SQ_WBEATS);
    assign cmd_fire   = cmd_valid && cmd_ready;
    assign rsp_valid  = (state_q == SQ_RSTREAM) || (state_q == SQ_RSINGLE);
    assign rsp_fire   = rsp_valid && rsp_ready;
    assign final_beat = bq.left == ONE_BEAT;

    assign rsp_last   = (state_q == SQ_RSINGLE) || ((state_q == SQ_RSTREAM) && final_beat);
    assign rsp_status = (state_q == SQ_RSINGLE) ? bq.err : STAT_OK;
    assign rsp_src    = bq.src;
    assign rsp_ctx    = bq.ctx;
    assign rsp_data   = (state_q == SQ_RSTREAM) ? ram_q : '0;
    assign ram_wdata  = cmd_data;
    assign ram_wmask  = cmd_mask;

    always_comb begin
        ram_we   = 1'b0;
        ram_re   = 1'b0;
        ram_addr = IX_W'(bq.cur);
        unique case (state_q)
            SQ_IDLE: begin
                ram_addr = IX_W'(dec_word);
                if (cmd_fire && !dec_oor) begin
                    ram_we = is_write;
                    ram_re = !is_write;
                end
            end
            SQ_WBEATS: begin
                ram_we = cmd_fire && !bq.err;
            end
            SQ_RSTREAM: begin
                ram_addr = IX_W'(bq.cur + WA_W'(1));
                ram_re   = rsp_fire && !final_beat;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            bq      <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (cmd_fire) begin
                    bq.src <= cmd_src;
                    bq.ctx <= cmd_ctx;
                    bq.err <= dec_oor;
                    if (is_write) begin
                        bq.cur  <= dec_word + WA_W'(1);
                        bq.left <= dec_beats - ONE_BEAT;
                        state_q <= (dec_beats == ONE_BEAT) ? SQ_RSINGLE : SQ_WBEATS;
                    end else begin
                        bq.cur  <= dec_word;
                        bq.left <= dec_beats;
                        state_q <= dec_oor ? SQ_RSINGLE : SQ_RSTREAM;
                    end
                end
                SQ_WBEATS: if (cmd_fire) begin
                    bq.cur  <= bq.cur + WA_W'(1);
                    bq.left <= bq.left - ONE_BEAT;
                    if (final_beat)
                        state_q <= SQ_RSINGLE;
                end
                SQ_RSTREAM: if (rsp_fire) begin
                    if (final_beat) begin
                        state_q <= SQ_IDLE;
                    end else begin
                        bq.cur  <= bq.cur + WA_W'(1);
                        bq.left <= bq.left - ONE_BEAT;
                    end
                end
                SQ_RSINGLE: if (rsp_fire) state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/burstram_slave.sv
module burstram_slave #(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 7,
    parameter int DATA_W = 32,
    parameter int SRC_W  = 4,
    parameter int CTX_W  = 5,
    parameter int DEPTH  = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic                 cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [LEN_W-1:0]     cmd_len,
    input  logic [SRC_W-1:0]     cmd_src,
    input  logic [CTX_W-1:0]     cmd_ctx,
    input  logic [DATA_W-1:0]    cmd_data,
    input  logic [DATA_W/8-1:0]  cmd_mask,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic                 rsp_status,
    output logic                 rsp_last,
    output logic [SRC_W-1:0]     rsp_src,
    output logic [CTX_W-1:0]     rsp_ctx,
    output logic [DATA_W-1:0]    rsp_data
);
    localparam int BPW  = DATA_W / 8;
    localparam int WA_W = ADDR_W - $clog2(BPW);
    localparam int IX_W = $clog2(DEPTH);

    logic [WA_W-1:0]   dec_word;
    logic [LEN_W:0]    dec_beats;
    logic              dec_oor;
    logic              ram_we;
    logic              ram_re;
    logic [IX_W-1:0]   ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [BPW-1:0]    ram_wmask;
    logic [DATA_W-1:0] ram_q;

    burstram_decode #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_decode (
        .byte_addr    (cmd_addr),
        .len          (cmd_len),
        .word_addr    (dec_word),
        .beats        (dec_beats),
        .out_of_range (dec_oor)
    );

    burstram_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
        .SRC_W(SRC_W), .CTX_W(CTX_W), .DEPTH(DEPTH)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_src    (cmd_src),
        .cmd_ctx    (cmd_ctx),
        .cmd_data   (cmd_data),
        .cmd_mask   (cmd_mask),
        .dec_word   (dec_word),
        .dec_beats  (dec_beats),
        .dec_oor    (dec_oor),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_status (rsp_status),
        .rsp_last   (rsp_last),
        .rsp_src    (rsp_src),
        .rsp_ctx    (rsp_ctx),
        .rsp_data   (rsp_data),
        .ram_we     (ram_we),
        .ram_re     (ram_re),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_wmask  (ram_wmask),
        .ram_q      (ram_q)
    );

    burstram_store #(
        .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .wmask (ram_wmask),
        .rdata (ram_q)
    );
endmodule

// File: rtl/burstram_chk.sv
module burstram_chk #(
    parameter int DATA_W = 32,
    parameter int SRC_W  = 4,
    parameter int CTX_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_op,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_status,
    input logic              rsp_last,
    input logic [SRC_W-1:0]  rsp_src,
    input logic [CTX_W-1:0]  rsp_ctx,
    input logic [DATA_W-1:0] rsp_data
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_src)
            && $stable(rsp_ctx) && $stable(rsp_status) && $stable(rsp_last));

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_ready);

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_status |-> rsp_last);

    // R5
    rd_turn_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && !cmd_op |=> rsp_valid);

    // R6
    echo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready && !rsp_last |=> rsp_valid && $stable(rsp_src) && $stable(rsp_ctx));

    // R4
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready && rsp_last |=> !rsp_valid);
endmodule

bind burstram_slave burstram_chk #(
    .DATA_W(DATA_W), .SRC_W(SRC_W), .CTX_W(CTX_W)
) u_chk (.*);

// File: tb/burstram_slave_bench.sv
`timescale 1ns/1ps
module burstram_slave_bench;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 7;
    localparam int DATA_W = 32;
    localparam int SRC_W  = 3;
    localparam int CTX_W  = 4;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic              cmd_op = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [SRC_W-1:0]  cmd_src = '0;
    logic [CTX_W-1:0]  cmd_ctx = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic [3:0]        cmd_mask = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic              rsp_status;
    logic              rsp_last;
    logic [SRC_W-1:0]  rsp_src;
    logic [CTX_W-1:0]  rsp_ctx;
    logic [DATA_W-1:0] rsp_data;

    logic [31:0] model [DEPTH];
    logic [7:0]  lfsr = 8'hB5;
    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    burstram_slave #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
        .SRC_W(SRC_W), .CTX_W(CTX_W), .DEPTH(DEPTH)
    ) u_burstram_slave (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_src(cmd_src), .cmd_ctx(cmd_ctx),
        .cmd_data(cmd_data), .cmd_mask(cmd_mask),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
        .rsp_last(rsp_last), .rsp_src(rsp_src), .rsp_ctx(rsp_ctx), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic next_ready(output logic r);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        r = lfsr[0] | lfsr[2];
    endtask

    function automatic int beats_of(input int len);
        return (len == 0) ? 1 : (len + 3) / 4;
    endfunction

    function automatic logic [3:0] rot_mask(input logic [3:0] m, input int r);
        logic [7:0] d;
        d = {m, m} << (r % 4);
        return d[7:4];
    endfunction

    task automatic do_read(input int baddr, input int len, input int src, input int ctx);
        int wa = baddr / 4;
        int nb = beats_of(len);
        bit err = (wa + nb) > DEPTH;
        int exp_n = err ? 1 : nb;
        int got = 0;
        int idle = 0;
        bit stalled = 0;
        logic [31:0] held = '0;
        logic r;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b0;
        cmd_addr = ADDR_W'(baddr); cmd_len = LEN_W'(len);
        cmd_src = SRC_W'(src); cmd_ctx = CTX_W'(ctx);
        rsp_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R5 first read beat one cycle after accept", 64'(rsp_valid), 1);
        while (got < exp_n && idle < 100) begin
            if (!rsp_valid) begin
                idle++;
            end else begin
                chk(rsp_status == err, "R7 read status", 64'(rsp_status), 64'(err));
                chk(rsp_last == (got == exp_n - 1), "R5 last flag", 64'(rsp_last), 64'(got == exp_n - 1));
                chk(rsp_src == SRC_W'(src) && rsp_ctx == CTX_W'(ctx), "R6 tag echo",
                    64'({rsp_src, rsp_ctx}), 64'({SRC_W'(src), CTX_W'(ctx)}));
                chk(!cmd_ready, "R8 request blocked during reply", 64'(cmd_ready), 0);
                if (!err)
                    chk(rsp_data == model[wa + got], "R2 read word", 64'(rsp_data), 64'(model[wa + got]));
                if (stalled)
                    chk(rsp_data == held, "R9 data held under stall", 64'(rsp_data), 64'(held));
                next_ready(r);
                rsp_ready = r;
                stalled = !r;
                held = rsp_data;
                if (r) got++;
            end
            @(negedge clk);
        end
        chk(got == exp_n, "R5 beat count", 64'(got), 64'(exp_n));
        chk(!rsp_valid, "R5 no beat after last", 64'(rsp_valid), 0);
        rsp_ready = 1'b0;
    endtask

    task automatic do_write(input int baddr, input int len, input int src, input int ctx,
                            input logic [31:0] seed, input logic [3:0] mbase);
        int wa = baddr / 4;
        int nb = beats_of(len);
        bit err = (wa + nb) > DEPTH;
        logic [31:0] d;
        logic [3:0]  m;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            d = seed ^ (32'(b) * 32'h0103_0507);
            m = rot_mask(mbase, b);
            cmd_valid = 1'b1; cmd_op = 1'b1;
            cmd_addr = ADDR_W'(baddr); cmd_len = LEN_W'(len);
            cmd_src = SRC_W'(src); cmd_ctx = CTX_W'(ctx);
            cmd_data = d; cmd_mask = m;
            chk(cmd_ready == 1'b1, "R4 write beat accepted", 64'(cmd_ready), 1);
            chk(!rsp_valid, "R4 no reply during beats", 64'(rsp_valid), 0);
            if (!err) begin
                for (int i = 0; i < 4; i++)
                    if (m[i]) model[wa + b][i*8 +: 8] = d[i*8 +: 8];
            end
            @(posedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(rsp_valid && rsp_last, "R4 single write reply", 64'({rsp_valid, rsp_last}), 3);
        chk(rsp_status == err, "R7 write status", 64'(rsp_status), 64'(err));
        chk(rsp_src == SRC_W'(src) && rsp_ctx == CTX_W'(ctx), "R6 write tag echo",
            64'({rsp_src, rsp_ctx}), 64'({SRC_W'(src), CTX_W'(ctx)}));
        chk(!cmd_ready, "R8 request blocked during write reply", 64'(cmd_ready), 0);
        rsp_ready = 1'b0;
        @(negedge clk);
        chk(rsp_valid && rsp_status == err && rsp_last, "R9 write reply held",
            64'({rsp_valid, rsp_status, rsp_last}), 64'({1'b1, err, 1'b1}));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid, "R4 exactly one reply", 64'(rsp_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n = 0;
        int lens [8] = '{0, 1, 3, 4, 5, 8, 16, 33};
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(cmd_ready == 1'b1, "R1 ready after reset", 64'(cmd_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no reply after reset", 64'(rsp_valid), 0);

        // R3 full-lane fill of every word, then full readback
        do_write(0, 64, 1, 2, 32'h5A1C_E703, 4'hF);
        do_read(0, 64, 3, 9);

        // R2 start word against lengths, unaligned byte addresses
        for (int wa = 0; wa < DEPTH; wa++) begin
            foreach (lens[k]) begin
                do_read(wa * 4 + (wa % 4), lens[k], n % 8, (n * 5) % 16);
                n++;
            end
        end

        // R3 all mask patterns over bursts of one to five words
        for (int m = 0; m < 16; m++) begin
            do_write(((m * 3) % 16) * 4 + (m % 4), (m % 5) * 4 + 1, m % 8, (m * 7) % 16,
                     32'(m) * 32'h1111_1111 ^ 32'hC3A5_0F96, 4'(m));
            do_read(0, 64, m % 8, m);
        end

        // R7 refused writes leave memory intact, refused long read
        do_write(60, 8, 5, 6, 32'hDEAD_BEEF, 4'hF);
        do_write(200, 4, 2, 11, 32'hFACE_CAFE, 4'hF);
        do_read(0, 64, 6, 1);
        do_read(0, 127, 7, 15);
        do_read(252, 0, 1, 3);

        // R2 zero-length write touches one word
        do_write(53, 0, 4, 8, 32'h0BAD_F00D, 4'hF);
        do_read(0, 64, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule